// File: doc/BRIEF.md
# Instruction Path Steering Classifier

This block sits at the head of a wide decode stage and sorts each 32-bit instruction word of a fetch bundle into a coarse class before full decode runs. It tells the downstream decoders which packet to consume for each slot: the scalar packet or the vector packet. It also pulls out the funct3 and funct6 fields that later vector ALU decode relies on. In that decode, funct3 picks the operand group and funct6 picks the operation.

The logic is purely combinational and is replicated once per slot. No slot looks at any other slot, so the critical path is the same at any bundle width. Two rules stop the classifier from routing on the major opcode alone. First, the load-FP and store-FP opcodes carry both scalar floating-point and vector memory accesses, so the width field must settle the path. Second, a static per-extension enable mask can force every instruction of a chosen extension to be flagged illegal. This lets bring-up and validation runs fence off one extension at a time. The illegal flag is handed to downstream exception handling.

The block has no clock and holds no state. Inputs are sampled whenever the consumer needs them, so it has no valid/ready pair and applies no back-pressure. A result is valid in the same cycle as the bundle that produced it.

Top module: `insn_route_classifier`

## Requirements
- R1: Each slot's outputs depend only on that slot's own instruction word and the enable mask, never on the words in other slots.
- R2: For every slot, funct3 output equals word bits [14:12] and funct6 output equals word bits [31:26], whether or not the word is legal.
- R3: A word whose bits [1:0] are not 2'b11, or whose major opcode (bits [6:0]) is not listed in R4 to R9, is illegal. Class codes: 0 illegal, 1 integer ALU, 2 branch/jump, 3 integer memory, 4 system/fence, 5 multiply/divide, 6 atomic, 7 FP memory, 8 FP compute, 9 vector memory, 10 vector ALU.
- R4: On opcodes 0x07 and 0x27, width bits [14:12] decide the class. Values 000, 101, 110 and 111 give class 9 and need V. Value 001 gives class 7 and needs Zfh. Value 010 gives class 7 and needs F. Value 011 gives class 7 and needs D. Value 100 is illegal.
- R5: Opcode 0x57 gives class 10 and needs V.
- R6: On opcodes 0x33 and 0x3B, funct7 bits [31:25] decide the class. 0000001 gives class 5 and needs M. 0010000 or 0000100 gives class 1 and needs Zba. 0000101 or 0110000 gives class 1 and needs Zbb. 0100100, 0010100 or 0110100 gives class 1 and needs Zbs. 0000000 or 0100000 gives class 1 and needs nothing. Any other funct7 is illegal.
- R7: On opcodes 0x53, 0x43, 0x47, 0x4B and 0x4F, the format bits [26:25] decide. 00 gives class 8 and needs F. 01 gives class 8 and needs D. 10 gives class 8 and needs Zfh. 11 is illegal.
- R8: Opcode 0x2F gives class 6 and needs A. Opcode 0x73 gives class 4, and needs H when funct3 is 100. Opcode 0x0F gives class 4, and needs the cache-block group when funct3 is 010.
- R9: Opcodes 0x13, 0x1B, 0x37 and 0x17 give class 1. Opcodes 0x63, 0x67 and 0x6F give class 2. Opcodes 0x03 and 0x23 give class 3. None of these needs an extension.
- R10: The illegal flag is 1 exactly when the class output is 0. The steering output is 1 (vector packet) exactly when the class is 9 or 10, and is 0 for illegal slots.
- R11: Enable mask bits, LSB first, are M, A, F, D, V, Zba, Zbb, Zbs, H, cache-block, Zfh. When the bit an instruction needs is 0, the slot is illegal with class 0 and steering 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bundle_in | input | SLOTS*32 | Instruction words, slot k at bits [32k+31:32k] |
| ext_enable | input | NUM_EXT | Static per-extension enable mask, order as in R11 |
| vec_steer | output | SLOTS | 1 selects the vector packet for the slot |
| insn_class | output | SLOTS*4 | Coarse class code per slot, slot k at [4k+3:4k] |
| illegal | output | SLOTS | Slot holds an illegal or disabled instruction |
| funct3_out | output | SLOTS*3 | Extracted funct3 per slot |
| funct6_out | output | SLOTS*6 | Extracted funct6 per slot |

## Verification
The hardest case to reach is a slot whose word is well-formed but whose one required extension is switched off. This case hides behind specific funct7, format or width values that a plain opcode walk rarely lands on. The bench therefore sweeps every opcode against every funct3 and every funct7 value, with all extensions on and with all off. It then repeats the sweep over the listed opcodes with each mask bit cleared on its own. The shared load-FP opcode is also driven as a real unit-stride 32-bit vector load in one slot while the neighbouring slots change every cycle.

// File: rtl/irc_pkg.sv
package irc_pkg;

  localparam int ILEN    = 32;
  localparam int OPC_W   = 7;
  localparam int CLS_W   = 4;
  localparam int NUM_EXT = 11;

  typedef enum logic [CLS_W-1:0] {
    CLS_ILLEGAL  = 4'd0,
    CLS_INT_ALU  = 4'd1,
    CLS_BRANCH   = 4'd2,
    CLS_INT_MEM  = 4'd3,
    CLS_SYSTEM   = 4'd4,
    CLS_MULDIV   = 4'd5,
    CLS_ATOMIC   = 4'd6,
    CLS_FP_MEM   = 4'd7,
    CLS_FP_ALU   = 4'd8,
    CLS_VEC_MEM  = 4'd9,
    CLS_VEC_ALU  = 4'd10
  } insn_class_e;

  // Extension group positions inside the enable mask
  localparam int EXT_M   = 0;
  localparam int EXT_A   = 1;
  localparam int EXT_F   = 2;
  localparam int EXT_D   = 3;
  localparam int EXT_V   = 4;
  localparam int EXT_ZBA = 5;
  localparam int EXT_ZBB = 6;
  localparam int EXT_ZBS = 7;
  localparam int EXT_H   = 8;
  localparam int EXT_CBO = 9;
  localparam int EXT_ZFH = 10;

  // Major opcodes
  localparam logic [OPC_W-1:0] OPC_LOAD      = 7'h03;
  localparam logic [OPC_W-1:0] OPC_LOAD_FP   = 7'h07;
  localparam logic [OPC_W-1:0] OPC_MISC_MEM  = 7'h0F;
  localparam logic [OPC_W-1:0] OPC_OP_IMM    = 7'h13;
  localparam logic [OPC_W-1:0] OPC_AUIPC     = 7'h17;
  localparam logic [OPC_W-1:0] OPC_OP_IMM_32 = 7'h1B;
  localparam logic [OPC_W-1:0] OPC_STORE     = 7'h23;
  localparam logic [OPC_W-1:0] OPC_STORE_FP  = 7'h27;
  localparam logic [OPC_W-1:0] OPC_AMO       = 7'h2F;
  localparam logic [OPC_W-1:0] OPC_OP        = 7'h33;
  localparam logic [OPC_W-1:0] OPC_LUI       = 7'h37;
  localparam logic [OPC_W-1:0] OPC_OP_32     = 7'h3B;
  localparam logic [OPC_W-1:0] OPC_MADD      = 7'h43;
  localparam logic [OPC_W-1:0] OPC_MSUB      = 7'h47;
  localparam logic [OPC_W-1:0] OPC_NMSUB     = 7'h4B;
  localparam logic [OPC_W-1:0] OPC_NMADD     = 7'h4F;
  localparam logic [OPC_W-1:0] OPC_OP_FP     = 7'h53;
  localparam logic [OPC_W-1:0] OPC_OP_V      = 7'h57;
  localparam logic [OPC_W-1:0] OPC_BRANCH    = 7'h63;
  localparam logic [OPC_W-1:0] OPC_JALR      = 7'h67;
  localparam logic [OPC_W-1:0] OPC_JAL       = 7'h6F;
  localparam logic [OPC_W-1:0] OPC_SYSTEM    = 7'h73;

endpackage

// File: rtl/irc_major_decode.sv
module irc_major_decode
  import irc_pkg::*;
#(
  parameter int N_EXT = NUM_EXT
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [2:0]        f3,
  input  logic [6:0]        f7,
  output insn_class_e       cls_raw,
  output logic [N_EXT-1:0]  need,
  output logic              bad
);

  always_comb begin
    cls_raw = CLS_ILLEGAL;
    need    = '0;
    bad     = 1'b0;
    if (opc[1:0] != 2'b11) begin
      bad = 1'b1;
    end else begin
      unique case (opc)
        OPC_LOAD, OPC_STORE: cls_raw = CLS_INT_MEM;
        OPC_OP_IMM, OPC_OP_IMM_32, OPC_LUI, OPC_AUIPC: cls_raw = CLS_INT_ALU;
        OPC_BRANCH, OPC_JAL, OPC_JALR: cls_raw = CLS_BRANCH;
        OPC_MISC_MEM: begin
          cls_raw = CLS_SYSTEM;
          if (f3 == 3'b010) need[EXT_CBO] = 1'b1;
        end
        OPC_SYSTEM: begin
          cls_raw = CLS_SYSTEM;
          if (f3 == 3'b100) need[EXT_H] = 1'b1;
        end
        OPC_AMO: begin
          cls_raw = CLS_ATOMIC;
          need[EXT_A] = 1'b1;
        end
        OPC_OP, OPC_OP_32: begin
          cls_raw = CLS_INT_ALU;
          unique case (f7)
            7'b0000001: begin cls_raw = CLS_MULDIV; need[EXT_M] = 1'b1; end
            7'b0010000, 7'b0000100: need[EXT_ZBA] = 1'b1;
            7'b0000101, 7'b0110000: need[EXT_ZBB] = 1'b1;
            7'b0100100, 7'b0010100, 7'b0110100: need[EXT_ZBS] = 1'b1;
            7'b0000000, 7'b0100000: ;
            default: bad = 1'b1;
          endcase
        end
        OPC_LOAD_FP, OPC_STORE_FP: begin
          // width field splits scalar FP from vector element accesses
          unique case (f3)
            3'b000, 3'b101, 3'b110, 3'b111: begin
              cls_raw = CLS_VEC_MEM; need[EXT_V] = 1'b1;
            end
            3'b001: begin cls_raw = CLS_FP_MEM; need[EXT_ZFH] = 1'b1; end
            3'b010: begin cls_raw = CLS_FP_MEM; need[EXT_F]   = 1'b1; end
            3'b011: begin cls_raw = CLS_FP_MEM; need[EXT_D]   = 1'b1; end
            default: bad = 1'b1;
          endcase
        end
        OPC_OP_V: begin
          cls_raw = CLS_VEC_ALU;
          need[EXT_V] = 1'b1;
        end
        OPC_OP_FP, OPC_MADD, OPC_MSUB, OPC_NMSUB, OPC_NMADD: begin
          cls_raw = CLS_FP_ALU;
          unique case (f7[1:0])
            2'b00: need[EXT_F]   = 1'b1;
            2'b01: need[EXT_D]   = 1'b1;
            2'b10: need[EXT_ZFH] = 1'b1;
            default: bad = 1'b1;
          endcase
        end
        default: bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/irc_ext_gate.sv
module irc_ext_gate
  import irc_pkg::*;
#(
  parameter int N_EXT = NUM_EXT
) (
  input  insn_class_e       cls_raw,
  input  logic [N_EXT-1:0]  need,
  input  logic              bad,
  input  logic [N_EXT-1:0]  enable,
  output insn_class_e       cls,
  output logic              illegal,
  output logic              steer
);

  logic disabled_hit;

  assign disabled_hit = |(need & ~enable);
  assign illegal      = bad | disabled_hit;
  assign cls          = illegal ? CLS_ILLEGAL : cls_raw;
  assign steer        = !illegal &&
                        (cls_raw == CLS_VEC_MEM || cls_raw == CLS_VEC_ALU);

endmodule

// File: rtl/irc_slot.sv
module irc_slot
  import irc_pkg::*;
#(
  parameter int N_EXT = NUM_EXT
) (
  input  logic [ILEN-1:0]   word,
  input  logic [N_EXT-1:0]  enable,
  output logic              steer,
  output logic [CLS_W-1:0]  cls_code,
  output logic              illegal,
  output logic [2:0]        f3,
  output logic [5:0]        f6
);

  insn_class_e        cls_raw;
  insn_class_e        cls;
  logic [N_EXT-1:0]   need;
  logic               bad;
  logic               slot_unused_bits;

  assign f3 = word[14:12];
  assign f6 = word[31:26];
  assign slot_unused_bits = ^{word[24:15], word[11:7]};

  irc_major_decode #(.N_EXT(N_EXT)) u_major (
    .opc     (word[6:0]),
    .f3      (word[14:12]),
    .f7      (word[31:25]),
    .cls_raw (cls_raw),
    .need    (need),
    .bad     (bad)
  );

  irc_ext_gate #(.N_EXT(N_EXT)) u_gate (
    .cls_raw (cls_raw),
    .need    (need),
    .bad     (bad),
    .enable  (enable),
    .cls     (cls),
    .illegal (illegal),
    .steer   (steer)
  );

  assign cls_code = cls;

endmodule

// File: rtl/insn_route_classifier.sv
module insn_route_classifier
  import irc_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int N_EXT = NUM_EXT
) (
  input  logic [SLOTS*ILEN-1:0]  bundle_in,
  input  logic [N_EXT-1:0]       ext_enable,
  output logic [SLOTS-1:0]       vec_steer,
  output logic [SLOTS*CLS_W-1:0] insn_class,
  output logic [SLOTS-1:0]       illegal,
  output logic [SLOTS*3-1:0]     funct3_out,
  output logic [SLOTS*6-1:0]     funct6_out
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    irc_slot #(.N_EXT(N_EXT)) u_slot (
      .word     (bundle_in[s*ILEN +: ILEN]),
      .enable   (ext_enable),
      .steer    (vec_steer[s]),
      .cls_code (insn_class[s*CLS_W +: CLS_W]),
      .illegal  (illegal[s]),
      .f3       (funct3_out[s*3 +: 3]),
      .f6       (funct6_out[s*6 +: 6])
    );
  end

endmodule

// File: rtl/irc_checker.sv
module irc_checker
  import irc_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int N_EXT = NUM_EXT
) (
  input logic [SLOTS*ILEN-1:0]  bundle_in,
  input logic [N_EXT-1:0]       ext_enable,
  input logic [SLOTS-1:0]       vec_steer,
  input logic [SLOTS*CLS_W-1:0] insn_class,
  input logic [SLOTS-1:0]       illegal,
  input logic [SLOTS*3-1:0]     funct3_out,
  input logic [SLOTS*6-1:0]     funct6_out
);

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      assert_illegal_class_R10: assert (illegal[s] == (insn_class[s*CLS_W +: CLS_W] == 4'd0))
        else $error("slot %0d illegal flag disagrees with class", s);
      assert_steer_vector_R10: assert (!vec_steer[s] ||
          insn_class[s*CLS_W +: CLS_W] == 4'd9 || insn_class[s*CLS_W +: CLS_W] == 4'd10)
        else $error("slot %0d steered to vector with a scalar class", s);
      assert_low_bits_R3: assert (bundle_in[s*ILEN +: 2] == 2'b11 || illegal[s])
        else $error("slot %0d short encoding not flagged", s);
      assert_vec_off_R5: assert (ext_enable[EXT_V] ||
          bundle_in[s*ILEN +: 7] != 7'h57 || illegal[s])
        else $error("slot %0d vector op passed with V disabled", s);
      assert_fp_width_R4: assert (!(bundle_in[s*ILEN +: 7] == 7'h07 &&
          bundle_in[s*ILEN+12 +: 3] == 3'b010 && ext_enable[EXT_F]) ||
          (insn_class[s*CLS_W +: CLS_W] == 4'd7 && !vec_steer[s]))
        else $error("slot %0d single-precision load misrouted", s);
      assert_field_R2: assert (funct3_out[s*3 +: 3] == bundle_in[s*ILEN+12 +: 3] &&
          funct6_out[s*6 +: 6] == bundle_in[s*ILEN+26 +: 6])
        else $error("slot %0d field extraction mismatch", s);
    end
  end

endmodule

bind insn_route_classifier irc_checker #(.SLOTS(SLOTS), .N_EXT(N_EXT)) u_irc_checker (
  .bundle_in  (bundle_in),
  .ext_enable (ext_enable),
  .vec_steer  (vec_steer),
  .insn_class (insn_class),
  .illegal    (illegal),
  .funct3_out (funct3_out),
  .funct6_out (funct6_out)
);

// File: tb/insn_route_classifier_tb.sv
module insn_route_classifier_tb;

  localparam int SLOTS = 8;
  localparam int NEXT  = 11;
  localparam int WATCHDOG = 180000;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [SLOTS*32-1:0] bundle_in;
  logic [NEXT-1:0]     ext_enable;
  logic [SLOTS-1:0]    vec_steer;
  logic [SLOTS*4-1:0]  insn_class;
  logic [SLOTS-1:0]    illegal;
  logic [SLOTS*3-1:0]  funct3_out;
  logic [SLOTS*6-1:0]  funct6_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  insn_route_classifier u_dut (
    .bundle_in  (bundle_in),
    .ext_enable (ext_enable),
    .vec_steer  (vec_steer),
    .insn_class (insn_class),
    .illegal    (illegal),
    .funct3_out (funct3_out),
    .funct6_out (funct6_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc >= WATCHDOG);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d cycles expected<%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Reference: required extension bit (-1 none), class, structural illegality
  function automatic void ref_model(input logic [31:0] w, input logic [NEXT-1:0] en,
                                    output int cls, output bit ill, output bit st);
    int need = -1;
    bit badw = 0;
    logic [6:0] op = w[6:0];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    cls = 0;
    if (op[1:0] != 2'b11) badw = 1;
    else if (op == 7'h03 || op == 7'h23) cls = 3;
    else if (op == 7'h13 || op == 7'h1B || op == 7'h37 || op == 7'h17) cls = 1;
    else if (op == 7'h63 || op == 7'h67 || op == 7'h6F) cls = 2;
    else if (op == 7'h0F) begin cls = 4; if (f3 == 3'd2) need = 9; end
    else if (op == 7'h73) begin cls = 4; if (f3 == 3'd4) need = 8; end
    else if (op == 7'h2F) begin cls = 6; need = 1; end
    else if (op == 7'h57) begin cls = 10; need = 4; end
    else if (op == 7'h33 || op == 7'h3B) begin
      cls = 1;
      if (f7 == 7'h01) begin cls = 5; need = 0; end
      else if (f7 == 7'h10 || f7 == 7'h04) need = 5;
      else if (f7 == 7'h05 || f7 == 7'h30) need = 6;
      else if (f7 == 7'h24 || f7 == 7'h14 || f7 == 7'h34) need = 7;
      else if (f7 != 7'h00 && f7 != 7'h20) badw = 1;
    end
    else if (op == 7'h07 || op == 7'h27) begin
      if (f3 == 0 || f3 >= 5) begin cls = 9; need = 4; end
      else if (f3 == 1) begin cls = 7; need = 10; end
      else if (f3 == 2) begin cls = 7; need = 2; end
      else if (f3 == 3) begin cls = 7; need = 3; end
      else badw = 1;
    end
    else if (op == 7'h53 || op == 7'h43 || op == 7'h47 || op == 7'h4B || op == 7'h4F) begin
      cls = 8;
      if (w[26:25] == 2'd0) need = 2;
      else if (w[26:25] == 2'd1) need = 3;
      else if (w[26:25] == 2'd2) need = 10;
      else badw = 1;
    end
    else badw = 1;
    ill = badw || (need >= 0 && !en[need]);
    if (ill) cls = 0;
    st = (cls == 9 || cls == 10);
  endfunction

  function automatic string tag_of(input logic [6:0] op);
    if (op[1:0] != 2'b11) return "R3";
    case (op)
      7'h07, 7'h27: return "R4";
      7'h57: return "R5";
      7'h33, 7'h3B: return "R6";
      7'h53, 7'h43, 7'h47, 7'h4B, 7'h4F: return "R7";
      7'h2F, 7'h73, 7'h0F: return "R8";
      7'h03, 7'h23, 7'h13, 7'h1B, 7'h37, 7'h17, 7'h63, 7'h67, 7'h6F: return "R9";
      default: return "R3";
    endcase
  endfunction

  // Apply one bundle at a posedge, sample at the following negedge
  task automatic run_bundle(input logic [31:0] w [SLOTS], input string phase);
    @(posedge clk);
    for (int s = 0; s < SLOTS; s++) bundle_in[s*32 +: 32] = w[s];
    @(negedge clk);
    for (int s = 0; s < SLOTS; s++) begin
      int ec; bit ei, es;
      int ac;
      string t;
      ref_model(w[s], ext_enable, ec, ei, es);
      ac = int'(insn_class[s*4 +: 4]);
      total++;
      if (funct3_out[s*3 +: 3] != w[s][14:12] || funct6_out[s*6 +: 6] != w[s][31:26]) begin
        bad++;
        $display("FAIL R2 slot %0d word %h f3/f6 actual=%0d/%0d expected=%0d/%0d", s, w[s],
                 funct3_out[s*3 +: 3], funct6_out[s*6 +: 6], w[s][14:12], w[s][31:26]);
      end else if (ac != ec || illegal[s] != ei || vec_steer[s] != es) begin
        bad++;
        t = (phase != "") ? phase : tag_of(w[s][6:0]);
        if (ac == ec) t = "R10";
        $display("FAIL %s slot %0d word %h mask %b actual cls=%0d ill=%0d st=%0d expected cls=%0d ill=%0d st=%0d",
                 t, s, w[s], ext_enable, ac, illegal[s], vec_steer[s], ec, ei, es);
      end
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int f3, input int f7, input int k);
    logic [9:0] p  = 10'(k * 37 + 5);
    logic [4:0] p2 = 5'(k * 11 + 3);
    return {7'(f7), p, 3'(f3), p2, 7'(op)};
  endfunction

  function automatic bit listed(input int op);
    case (7'(op))
      7'h03, 7'h07, 7'h0F, 7'h13, 7'h17, 7'h1B, 7'h23, 7'h27, 7'h2F, 7'h33, 7'h37,
      7'h3B, 7'h43, 7'h47, 7'h4B, 7'h4F, 7'h53, 7'h57, 7'h63, 7'h67, 7'h6F, 7'h73: return 1;
      default: return 0;
    endcase
  endfunction

  // Full sweep: every opcode x funct3 x funct7; slots hold different words (R1)
  task automatic sweep(input bit only_listed, input string phase);
    logic [31:0] w [SLOTS];
    int n = 0;
    for (int op = 0; op < 128; op++) begin
      if (only_listed && !listed(op)) continue;
      for (int f3 = 0; f3 < 8; f3++)
        for (int f7 = 0; f7 < 128; f7++) begin
          w[n] = mk(op, f3, f7, op + f3 + f7);
          n++;
          if (n == SLOTS) begin run_bundle(w, phase); n = 0; end
        end
    end
  endtask

  initial begin
    logic [31:0] w [SLOTS];
    bundle_in  = '0;
    ext_enable = '1;
    // Idle state: all-zero words have bits [1:0]=00 -> illegal (R3)
    for (int s = 0; s < SLOTS; s++) w[s] = 32'h0;
    run_bundle(w, "R3");

    // R4: unit-stride 32-bit vector load on the load-FP opcode must go vector
    for (int s = 0; s < SLOTS; s++) w[s] = 32'h0205E287;
    run_bundle(w, "R4");
    // R4: same opcode with width 010 is a scalar single load
    for (int s = 0; s < SLOTS; s++) w[s] = 32'h0005A287;
    run_bundle(w, "R4");

    // R1: slot 5 held at a vector load while neighbours change every cycle
    for (int it = 0; it < 64; it++) begin
      for (int s = 0; s < SLOTS; s++) w[s] = mk((it * 13 + s * 29) % 128, it % 8, (it * 7 + s) % 128, it);
      w[5] = 32'h0205E287;
      run_bundle(w, "R1");
    end

    // Near-exhaustive sweeps, all extensions on and then all off (R11)
    ext_enable = '1;
    sweep(0, "");
    ext_enable = '0;
    sweep(0, "");

    // One extension group cleared at a time (R11)
    for (int b = 0; b < NEXT; b++) begin
      ext_enable = '1;
      ext_enable[b] = 1'b0;
      sweep(1, "R11");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule